// File: doc/BRIEF.md
# Serial EEPROM Boot Reader

This block reads the contents of a three-wire serial EEPROM by itself as soon as reset is released. It steps through a fixed number of 16-bit words, lowest address first, issuing one read command per word over chip select, shift clock and data-in, and shifting each answer back in from data-out. The words are kept in an internal image, and a 48-bit station address is assembled from six consecutive bytes of that image.

The pin timing is built from phases. Each phase lasts a number of system clocks chosen by the `phase_len` input, or by a parameter default when that input is zero, so the same block can serve fast and slow serial parts. When the last word has been stored, `done` rises and stays high, and all EEPROM pins are parked low until the next reset.

Top module: `sprom_boot_reader`

## Requirements
- R1: While reset is active and in the first system clock after it, `ee_cs`, `ee_sk`, `ee_di` and `done` are 0 and `word_image` is all zeros.
- R2: Every phase lasts `phase_len` system clocks; a `phase_len` of 0 selects the parameter default of 4.
- R3: Each word access starts with one phase of chip select low, then one phase of chip select high, with the shift clock low in both.
- R4: The read command is 11 bits sent MSB first: 0, 0, 1, 1, 0, then the 6-bit word address; each bit is placed on `ee_di` in a clock-low phase and held through the following clock-high phase.
- R5: After the command, one phase with clock and data-in low, then 16 data bits MSB first, each a clock-high phase followed by a clock-low phase; `ee_do` is sampled on the last system clock of the clock-high phase.
- R6: Word addresses 0 to 15 are read once each, in ascending order.
- R7: Word w is held in `word_image[16w+15:16w]`; in the byte image, byte 2w is the low byte of word w and byte 2w+1 its high byte.
- R8: `station_addr` is image bytes 20 to 25 with byte 20 in bits 47:40 and byte 25 in bits 7:0.
- R9: The shift clock is low in any cycle where chip select changes and in the cycle before it.
- R10: `done` rises on the clock edge that stores the 16th word and stays high; from then on all three EEPROM outputs stay low until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; releasing it starts the read burst |
| phase_len | input | 8 | System clocks per serial phase; 0 selects the default |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM shift clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| word_image | output | 256 | All words read, word 0 in the low bits |
| station_addr | output | 48 | Station address from image bytes 20 to 25 |
| done | output | 1 | High once every word is stored |

## Verification
The bench builds the block with its default parameters (16 words, 6-bit addresses, default phase of 4) and runs three bursts with `phase_len` set to 0, 1 and 3. The zero setting reaches the default path, while a length of 1 puts the sample on the only clock of a clock-high phase, the tightest case for the EEPROM answer to arrive. A behavioural EEPROM answers the commands it decodes from the pins, so the address order and the data path are checked from the serial side as well as against a cycle-by-cycle queue of expected pin states.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

   typedef struct packed {
      logic cs;
      logic sk;
      logic di;
   } pins_t;

   localparam int unsigned LEAD_ZEROS = 2;
   localparam logic        START_BIT  = 1'b1;
   localparam logic [1:0]  READ_OP    = 2'b10;
   localparam int unsigned CMD_HDR_W  = LEAD_ZEROS + 1 + 2;

endpackage

// File: rtl/sprom_phase_div.sv
module sprom_phase_div #(
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned DEF_PHASE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] len,
   output logic             tick
);
   localparam logic [DIV_W-1:0] DEF_L = DIV_W'(DEF_PHASE);

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] eff_len;

   assign eff_len = (len == '0) ? DEF_L : len;
   assign tick    = run && (cnt_q == eff_len - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!run)     cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/sprom_seq.sv
module sprom_seq
   import sprom_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned NWORDS = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ee_do,
   output logic              run,
   output pins_t             pins,
   output logic              done,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [WORD_W-1:0] wr_data
);
   localparam int CMD_W     = CMD_HDR_W + ADDR_W;
   localparam int CMD0      = 2;
   localparam int GAP       = CMD0 + 2 * CMD_W;
   localparam int DAT0      = GAP + 1;
   localparam int STEPS     = DAT0 + 2 * WORD_W;
   localparam int STEP_W    = $clog2(STEPS);

   logic [STEP_W-1:0] step_q, step_n;
   logic [IDX_W-1:0]  word_q, word_n;
   logic [WORD_W-1:0] shf_q, shf_n;
   logic              done_q, done_n;
   pins_t             pins_q;

   function automatic pins_t decode(input logic [STEP_W-1:0] s,
                                    input logic [IDX_W-1:0]  w,
                                    input logic              fin);
      pins_t            p;
      logic [CMD_W-1:0] cmd;
      int               si;
      int               k;
      p   = '0;
      cmd = {{LEAD_ZEROS{1'b0}}, START_BIT, READ_OP, ADDR_W'(w)};
      si  = int'(s);
      if (!fin && si != 0) begin
         p.cs = 1'b1;
         if (si >= CMD0 && si < GAP) begin
            k    = si - CMD0;
            p.sk = k[0];
            p.di = cmd[CMD_W - 1 - (k >> 1)];
         end else if (si >= DAT0) begin
            k    = si - DAT0;
            p.sk = ~k[0];
         end
      end
      return p;
   endfunction

   always_comb begin
      int si;
      step_n = step_q;
      word_n = word_q;
      shf_n  = shf_q;
      done_n = done_q;
      wr_en  = 1'b0;
      si     = int'(step_q);
      if (tick && !done_q) begin
         if (si >= DAT0 && ((si - DAT0) % 2) == 0)
            shf_n = {shf_q[WORD_W-2:0], ee_do};
         if (si == STEPS - 1) begin
            wr_en  = 1'b1;
            step_n = '0;
            if (int'(word_q) == NWORDS - 1) done_n = 1'b1;
            else                            word_n = word_q + 1'b1;
         end else begin
            step_n = step_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= '0;
         word_q <= '0;
         shf_q  <= '0;
         done_q <= 1'b0;
         pins_q <= '0;
      end else begin
         step_q <= step_n;
         word_q <= word_n;
         shf_q  <= shf_n;
         done_q <= done_n;
         pins_q <= decode(step_n, word_n, done_n);
      end
   end

   assign run     = !done_q;
   assign pins    = pins_q;
   assign done    = done_q;
   assign wr_idx  = word_q;
   assign wr_data = shf_q;

   // R9: shift clock quiet around every chip-select change
   p_sk_quiet_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pins_q.cs != $past(pins_q.cs)) |-> (!pins_q.sk && !$past(pins_q.sk)));

   // R4: data-in held across a rising shift clock
   p_di_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pins_q.sk) |-> (pins_q.di == $past(pins_q.di)));

   // R10: done is sticky
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q);

   // R10: pins parked once done
   p_idle_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (pins_q == '0));

   // R2: sequence position moves only on a phase tick from the divider
   p_step_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(tick) |-> ($stable(step_q) && $stable(word_q)));

endmodule

// File: rtl/sprom_image.sv
module sprom_image #(
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NWORDS    = 16,
   parameter int unsigned IDX_W     = 4,
   parameter int unsigned MAC_OFS   = 20,
   parameter int unsigned MAC_BYTES = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [WORD_W-1:0]        wr_data,
   output logic [NWORDS*WORD_W-1:0] image,
   output logic [8*MAC_BYTES-1:0]   mac
);
   logic [WORD_W-1:0] mem [NWORDS];

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)                                 mem[w] <= '0;
         else if (wr_en && int'(wr_idx) == w)        mem[w] <= wr_data;
      end
      assign image[w*WORD_W +: WORD_W] = mem[w];
   end

   for (genvar b = 0; b < MAC_BYTES; b++) begin : g_mac
      localparam int unsigned BYTE_IDX = MAC_OFS + b;
      localparam int unsigned SRC_W    = BYTE_IDX / 2;
      if (BYTE_IDX % 2 == 1) begin : g_hi
         assign mac[8*(MAC_BYTES-b)-1 -: 8] = mem[SRC_W][15:8];
      end else begin : g_lo
         assign mac[8*(MAC_BYTES-b)-1 -: 8] = mem[SRC_W][7:0];
      end
   end

endmodule

// File: rtl/sprom_boot_reader.sv
module sprom_boot_reader
   import sprom_pkg::*;
#(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned WORD_W    = 16,
   parameter int unsigned NWORDS    = 16,
   parameter int unsigned MAC_OFS   = 20,
   parameter int unsigned MAC_BYTES = 6,
   parameter int unsigned DIV_W     = 8,
   parameter int unsigned DEF_PHASE = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [DIV_W-1:0]         phase_len,
   output logic                     ee_cs,
   output logic                     ee_sk,
   output logic                     ee_di,
   input  logic                     ee_do,
   output logic [NWORDS*WORD_W-1:0] word_image,
   output logic [8*MAC_BYTES-1:0]   station_addr,
   output logic                     done
);
   localparam int unsigned IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;

   initial begin
      a_word16:   assert (WORD_W == 16)                      else $error("WORD_W must be 16");
      a_fit:      assert (NWORDS <= (1 << ADDR_W))           else $error("NWORDS exceeds address space");
      a_idx:      assert (IDX_W <= ADDR_W)                   else $error("index wider than address");
      a_mac:      assert (MAC_OFS + MAC_BYTES <= 2 * NWORDS) else $error("address bytes outside image");
      a_min:      assert (NWORDS >= 2)                       else $error("NWORDS too small");
      a_def:      assert (DEF_PHASE >= 1 && DEF_PHASE < (1 << DIV_W)) else $error("bad DEF_PHASE");
   end

   logic              tick;
   logic              run;
   pins_t             pins;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [WORD_W-1:0] wr_data;

   sprom_phase_div #(
      .DIV_W     (DIV_W),
      .DEF_PHASE (DEF_PHASE)
   ) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .len   (phase_len),
      .tick  (tick)
   );

   sprom_seq #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W),
      .NWORDS (NWORDS),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .ee_do   (ee_do),
      .run     (run),
      .pins    (pins),
      .done    (done),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data)
   );

   sprom_image #(
      .WORD_W    (WORD_W),
      .NWORDS    (NWORDS),
      .IDX_W     (IDX_W),
      .MAC_OFS   (MAC_OFS),
      .MAC_BYTES (MAC_BYTES)
   ) u_img (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .image   (word_image),
      .mac     (station_addr)
   );

   assign ee_cs = pins.cs;
   assign ee_sk = pins.sk;
   assign ee_di = pins.di;

   // R7: a word slot only changes on a store, and never once done
   p_image_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(done) |-> $stable(word_image));

endmodule

// File: tb/sprom_boot_reader_tb.sv
module sprom_boot_reader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NW         = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   phase_len = 8'd0;
   logic         ee_cs, ee_sk, ee_di;
   logic         ee_do = 1'b1;
   logic [255:0] word_image;
   logic [47:0]  station_addr;
   logic         done;

   int checks = 0;
   int failures = 0;
   int cyc = 0;

   logic [15:0] rom [NW];
   logic [2:0]  exp_q [$];

   // behavioural EEPROM state
   int          s_cnt, s_didx, s_words;
   logic [10:0] s_cmd;
   logic [5:0]  s_addr;
   logic        prev_sk;

   always #(CLK_PERIOD/2) clk = ~clk;

   sprom_boot_reader u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_len    (phase_len),
      .ee_cs        (ee_cs),
      .ee_sk        (ee_sk),
      .ee_di        (ee_di),
      .ee_do        (ee_do),
      .word_image   (word_image),
      .station_addr (station_addr),
      .done         (done)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", what, act, expv);
      end
   endtask

   task automatic push_n(input logic [2:0] v, input int n);
      for (int i = 0; i < n; i++) exp_q.push_back(v);
   endtask

   // expected {cs,sk,di} per system clock, per R2 R3 R4 R5 R6
   task automatic build_expect(input int len);
      logic [10:0] cmd;
      exp_q.delete();
      for (int w = 0; w < NW; w++) begin
         push_n(3'b000, len);                 // R3 select low
         push_n(3'b100, len);                 // R3 select high
         cmd = {2'b00, 1'b1, 2'b10, 6'(w)};
         for (int j = 10; j >= 0; j--) begin  // R4
            push_n({2'b10, cmd[j]}, len);
            push_n({2'b11, cmd[j]}, len);
         end
         push_n(3'b100, len);                 // R5 gap
         for (int b = 0; b < 16; b++) begin   // R5 data
            push_n(3'b110, len);
            push_n(3'b100, len);
         end
      end
   endtask

   task automatic slave_step();
      if (!ee_cs) begin
         s_cnt  = 0;
         s_didx = 0;
         ee_do  = 1'b1;
      end else if (ee_sk && !prev_sk) begin
         if (s_cnt < 11) begin
            s_cmd = {s_cmd[9:0], ee_di};
            s_cnt++;
            if (s_cnt == 11) begin
               chk(s_cmd == {2'b00, 1'b1, 2'b10, 6'(s_words)},
                   "R4 R6 command received", 64'(s_cmd),
                   64'({2'b00, 1'b1, 2'b10, 6'(s_words)}));
               s_addr = s_cmd[5:0];
               s_words++;
            end
         end else begin
            ee_do = rom[s_addr[3:0]][15 - s_didx];
            s_didx++;
         end
      end
      prev_sk = ee_sk;
   endtask

   task automatic run_burst(input int plen, input int seed);
      int len, total;
      logic [47:0] exp_mac;
      logic [7:0]  byt;
      logic [3:0]  exp_pins;
      rst_n     = 1'b0;
      phase_len = 8'(plen);
      for (int i = 0; i < NW; i++)
         rom[i] = 16'((seed * 16'h2F1B) ^ (i * 16'h0B3D) ^ (i << 11) ^ seed);
      ee_do = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({ee_cs, ee_sk, ee_di, done} == 4'b0000, "R1 pins and done in reset",
          64'({ee_cs, ee_sk, ee_di, done}), 64'h0);
      chk(word_image == '0, "R1 image cleared in reset", word_image[63:0], 64'h0);
      len = (plen == 0) ? 4 : plen;
      build_expect(len);
      total   = exp_q.size();
      s_cnt   = 0;
      s_didx  = 0;
      s_words = 0;
      s_cmd   = '0;
      s_addr  = '0;
      prev_sk = 1'b0;
      rst_n   = 1'b1;
      for (int i = 0; i < total + 40; i++) begin
         if (exp_q.size() > 0) exp_pins = {exp_q.pop_front(), 1'b0};
         else                  exp_pins = 4'b0001;
         chk({ee_cs, ee_sk, ee_di, done} == exp_pins,
             $sformatf("R2 R3 R4 R5 R9 R10 pins/done cycle %0d len %0d", i, len),
             64'({ee_cs, ee_sk, ee_di, done}), 64'(exp_pins));
         slave_step();
         @(negedge clk);
      end
      chk(s_words == NW, "R6 number of commands", 64'(s_words), 64'(NW));
      for (int w = 0; w < NW; w++)
         chk(word_image[w*16 +: 16] == rom[w], $sformatf("R7 word %0d", w),
             64'(word_image[w*16 +: 16]), 64'(rom[w]));
      exp_mac = '0;
      for (int b = 20; b < 26; b++) begin
         byt = (b % 2 == 1) ? rom[b/2][15:8] : rom[b/2][7:0];
         exp_mac = {exp_mac[39:0], byt};
      end
      chk(station_addr == exp_mac, "R8 station address", 64'(station_addr), 64'(exp_mac));
      chk(done == 1'b1, "R10 done held", 64'(done), 64'h1);
   endtask

   initial begin
      run_burst(0, 7);    // R2 default phase
      run_burst(1, 41);
      run_burst(3, 1234);
      summary();
      $finish;
   end

endmodule